// File: doc/BRIEF.md
# RV32I Single-Cycle Control Decoder

This block is the control unit of a single-cycle RV32I core. It looks only at the fields of the instruction in flight: the major opcode, the three-bit function field and the seven-bit function field. It also reads the ALU zero flag and the two low bits of the ALU result, which hold the effective address for stores. From these it produces eleven control signals that steer the datapath in the same cycle. Five of them are multiplexer selects: the writeback result, the second ALU operand, the next PC, the base of the jump target and the immediate format. A sixth select sets the width and extension of load data. The rest are the lowest-bit clear for indirect jump targets, a load strobe, the register write enable, a per-byte store lane enable and the ALU operation code.

The block holds no state. Every output is a function of the present inputs only. The interface carries control, not a data stream, so every pin is a plain level with no handshake.

Conditional branches are resolved from the zero flag alone. The decoder asks the ALU for a subtraction, a signed compare or an unsigned compare, and then reads the zero flag with a polarity set by the function field.

An encoding the block does not recognise gets a quiet bundle: no register write, no store lane, no load strobe and no redirect. This covers reserved function codes, fence and the system opcode.

Top module: `rv32_ctl_decoder`

## Requirements
- R1: Register-register ops (opcode 0110011) give reg_we=1, alu_b_sel=0 (register), res_sel=0 (ALU) and imm_fmt=0. alu_op by funct3 is 000 add(0) or sub(1), 001 sll(7), 010 slt(5), 011 sltu(6), 100 xor(4), 101 srl(8) or sra(9), 110 or(3), 111 and(2). sub and sra are chosen by funct7=0100000. Any funct7 other than 0000000, or 0100000 with funct3 000/101, is unrecognised.
- R2: Immediate ALU ops (opcode 0010011) give reg_we=1, alu_b_sel=1 (immediate), imm_fmt=0 (I) and res_sel=0, with alu_op as in R1. Exceptions: funct3 000 is always add, whatever funct7 bit 30 holds. funct3 001 needs funct7=0000000. funct3 101 takes srl or sra from funct7 0000000 or 0100000, and any other funct7 there is unrecognised.
- R3: Loads (opcode 0000011) with funct3 000/001/010/100/101 give mem_rd=1, reg_we=1, res_sel=1 (memory), alu_b_sel=1, imm_fmt=0, alu_op add and rd_mask=funct3. The rd_mask codes are 0 signed byte, 1 signed half, 2 word, 4 unsigned byte and 5 unsigned half. Every other instruction gives rd_mask=2. Any other load funct3 is unrecognised.
- R4: Stores (opcode 0100011) give imm_fmt=1 (S), alu_b_sel=1, alu_op add and reg_we=0. mem_we bit k is byte lane k. sb (funct3 000) sets the bit selected by addr_lo. sh (001) sets 0011 at addr_lo 0, 1100 at addr_lo 2, and nothing at an odd address. sw (010) sets 1111 at addr_lo 0 and nothing otherwise. Any other store funct3 is unrecognised.
- R5: Branches (opcode 1100011) give imm_fmt=2 (B) and no register, store or load activity. alu_op is sub for funct3 000/001, slt for 100/101 and sltu for 110/111. pc_sel=1 when alu_zero=1 for beq/bge/bgeu, or when alu_zero=0 for bne/blt/bltu. funct3 010/011 are unrecognised.
- R6: jal (opcode 1101111) gives pc_sel=1, tgt_base_sel=0 (PC), res_sel=2 (PC+4), imm_fmt=4 (J) and reg_we=1.
- R7: jalr (opcode 1100111, funct3 000) gives pc_sel=1, tgt_base_sel=1 (rs1), tgt_lsb_clr=1, alu_b_sel=1, imm_fmt=0, res_sel=2 and reg_we=1. Any other funct3 is unrecognised.
- R8: lui (0110111) gives res_sel=3 (immediate) and auipc (0010111) gives res_sel=4 (PC-relative target), both with imm_fmt=3 (U), reg_we=1 and tgt_base_sel=0.
- R9: Any unrecognised encoding, including opcodes 0001111 and 1110011, gives reg_we=0, mem_we=0, mem_rd=0 and pc_sel=0, with all other outputs at 0 except rd_mask=2.
- R10: Outputs depend only on the present inputs: the same inputs give the same bundle whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Major opcode field of the instruction |
| funct3_i | input | 3 | Three-bit function field |
| funct7_i | input | 7 | Seven-bit function field |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| addr_lo_i | input | 2 | Low bits of the ALU result (effective address) |
| res_sel_o | output | 3 | Writeback result select |
| alu_b_sel_o | output | 1 | ALU second operand: 0 register, 1 immediate |
| pc_sel_o | output | 1 | Next PC: 0 PC+4, 1 computed target |
| tgt_base_sel_o | output | 1 | Target adder base: 0 PC, 1 rs1 |
| tgt_lsb_clr_o | output | 1 | Clear bit 0 of the computed target |
| imm_fmt_o | output | 3 | Immediate format select |
| rd_mask_o | output | 3 | Load width and extension select |
| mem_rd_o | output | 1 | Load strobe |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 4 | Per-byte store lane enables |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The bench builds the decoder with its defaults: four byte lanes and strict seven-bit function checking. The four lanes expose every byte and halfword placement, including the misaligned addresses where no lane may fire. Strict checking makes reserved function-field values reachable, and these must collapse to the quiet bundle. Every branch condition is driven with both values of the zero flag. A vector is repeated after unrelated traffic to show that the outputs have no memory.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int ALUOP_W = 4;
  localparam int SEL3_W  = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    CLS_ILL, CLS_OP, CLS_OPIMM, CLS_LOAD, CLS_STORE,
    CLS_BRANCH, CLS_JAL, CLS_JALR, CLS_LUI, CLS_AUIPC
  } cls_e;

  typedef enum logic [SEL3_W-1:0] {
    RES_ALU = 3'd0, RES_MEM = 3'd1, RES_PC4 = 3'd2, RES_IMM = 3'd3, RES_TGT = 3'd4
  } res_sel_e;

  typedef enum logic [SEL3_W-1:0] {
    IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
  } imm_fmt_e;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3, ALU_XOR = 4'd4,
    ALU_SLT = 4'd5, ALU_SLTU = 4'd6, ALU_SLL = 4'd7, ALU_SRL = 4'd8, ALU_SRA = 4'd9
  } alu_op_e;

  localparam logic [SEL3_W-1:0] MASK_WORD = 3'd2;
endpackage

// File: rtl/ctl_class_dec.sv
module ctl_class_dec
  import ctl_pkg::*;
#(
  parameter bit STRICT_F7 = 1'b1
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [F3_W-1:0]  funct3,
  input  logic [F7_W-1:0]  funct7,
  output cls_e             cls
);
  logic f7_op_ok;
  logic f7_imm_ok;

  generate
    if (STRICT_F7) begin : g_strict
      always_comb begin
        f7_op_ok = (funct7 == F7_BASE) ||
                   ((funct7 == F7_ALT) && (funct3 == 3'b000 || funct3 == 3'b101));
        unique case (funct3)
          3'b001:  f7_imm_ok = (funct7 == F7_BASE);
          3'b101:  f7_imm_ok = (funct7 == F7_BASE) || (funct7 == F7_ALT);
          default: f7_imm_ok = 1'b1;
        endcase
      end
    end else begin : g_loose
      logic [F7_W-1:0] f7_unused;
      assign f7_unused = funct7;
      assign f7_op_ok  = 1'b1;
      assign f7_imm_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    cls = CLS_ILL;
    unique case (opcode)
      OPC_OP:     if (f7_op_ok) cls = CLS_OP;
      OPC_OPIMM:  if (f7_imm_ok) cls = CLS_OPIMM;
      OPC_LOAD:   if (funct3 != 3'b011 && funct3 != 3'b110 && funct3 != 3'b111) cls = CLS_LOAD;
      OPC_STORE:  if (funct3[2] == 1'b0 && funct3[1:0] != 2'b11) cls = CLS_STORE;
      OPC_BRANCH: if (funct3[2:1] != 2'b01) cls = CLS_BRANCH;
      OPC_JAL:    cls = CLS_JAL;
      OPC_JALR:   if (funct3 == 3'b000) cls = CLS_JALR;
      OPC_LUI:    cls = CLS_LUI;
      OPC_AUIPC:  cls = CLS_AUIPC;
      default:    cls = CLS_ILL;
    endcase
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  cls_e            cls,
  input  logic [F3_W-1:0] funct3,
  input  logic            alt_bit,
  output alu_op_e         alu_op
);
  alu_op_e arith_op;

  always_comb begin
    unique case (funct3)
      3'b000:  arith_op = (alt_bit && cls == CLS_OP) ? ALU_SUB : ALU_ADD;
      3'b001:  arith_op = ALU_SLL;
      3'b010:  arith_op = ALU_SLT;
      3'b011:  arith_op = ALU_SLTU;
      3'b100:  arith_op = ALU_XOR;
      3'b101:  arith_op = alt_bit ? ALU_SRA : ALU_SRL;
      3'b110:  arith_op = ALU_OR;
      default: arith_op = ALU_AND;
    endcase
  end

  always_comb begin
    unique case (cls)
      CLS_OP, CLS_OPIMM: alu_op = arith_op;
      CLS_BRANCH: begin
        if (!funct3[2])     alu_op = ALU_SUB;
        else if (funct3[1]) alu_op = ALU_SLTU;
        else                alu_op = ALU_SLT;
      end
      default: alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/ctl_mem_dec.sv
module ctl_mem_dec
  import ctl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LANE_IDX_W = $clog2(LANES)
) (
  input  cls_e                  cls,
  input  logic [F3_W-1:0]       funct3,
  input  logic [LANE_IDX_W-1:0] addr_lo,
  output logic [LANES-1:0]      mem_we,
  output logic [SEL3_W-1:0]     rd_mask,
  output logic                  mem_rd
);
  logic [LANES-1:0] byte_hit;
  logic [LANES-1:0] half_hit;
  logic             word_hit;

  assign word_hit = (addr_lo == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign byte_hit[i] = (addr_lo == LANE_IDX_W'(i));
    assign half_hit[i] = !addr_lo[0] &&
                         ((addr_lo >> 1) == LANE_IDX_W'(i / 2));
  end

  always_comb begin
    mem_we = '0;
    if (cls == CLS_STORE) begin
      unique case (funct3[1:0])
        2'b00:   mem_we = byte_hit;
        2'b01:   mem_we = half_hit;
        default: mem_we = word_hit ? {LANES{1'b1}} : '0;
      endcase
    end
  end

  assign mem_rd  = (cls == CLS_LOAD);
  assign rd_mask = mem_rd ? funct3 : MASK_WORD;
endmodule

// File: rtl/ctl_flow_dec.sv
module ctl_flow_dec
  import ctl_pkg::*;
(
  input  cls_e            cls,
  input  logic [F3_W-1:0] funct3,
  input  logic            alu_zero,
  output logic            pc_sel,
  output logic            tgt_base_sel,
  output logic            tgt_lsb_clr
);
  logic taken;

  always_comb begin
    unique case (funct3)
      3'b000, 3'b101, 3'b111: taken = alu_zero;
      3'b001, 3'b100, 3'b110: taken = !alu_zero;
      default:                taken = 1'b0;
    endcase
  end

  always_comb begin
    pc_sel       = 1'b0;
    tgt_base_sel = 1'b0;
    tgt_lsb_clr  = 1'b0;
    unique case (cls)
      CLS_JAL:    pc_sel = 1'b1;
      CLS_JALR: begin
        pc_sel       = 1'b1;
        tgt_base_sel = 1'b1;
        tgt_lsb_clr  = 1'b1;
      end
      CLS_BRANCH: pc_sel = taken;
      default: ;
    endcase
  end
endmodule

// File: rtl/rv32_ctl_decoder.sv
module rv32_ctl_decoder
  import ctl_pkg::*;
#(
  parameter int LANES     = 4,
  parameter bit STRICT_F7 = 1'b1,
  localparam int LANE_IDX_W = $clog2(LANES)
) (
  input  logic [6:0]            opcode_i,
  input  logic [2:0]            funct3_i,
  input  logic [6:0]            funct7_i,
  input  logic                  alu_zero_i,
  input  logic [LANE_IDX_W-1:0] addr_lo_i,
  output logic [2:0]            res_sel_o,
  output logic                  alu_b_sel_o,
  output logic                  pc_sel_o,
  output logic                  tgt_base_sel_o,
  output logic                  tgt_lsb_clr_o,
  output logic [2:0]            imm_fmt_o,
  output logic [2:0]            rd_mask_o,
  output logic                  mem_rd_o,
  output logic                  reg_we_o,
  output logic [LANES-1:0]      mem_we_o,
  output logic [3:0]            alu_op_o
);
  cls_e     cls;
  alu_op_e  alu_op;
  res_sel_e res_sel;
  imm_fmt_e imm_fmt;

  ctl_class_dec #(.STRICT_F7(STRICT_F7)) u_class (
    .opcode (opcode_i),
    .funct3 (funct3_i),
    .funct7 (funct7_i),
    .cls    (cls)
  );

  ctl_alu_dec u_alu (
    .cls     (cls),
    .funct3  (funct3_i),
    .alt_bit (funct7_i[5]),
    .alu_op  (alu_op)
  );

  ctl_mem_dec #(.LANES(LANES)) u_mem (
    .cls     (cls),
    .funct3  (funct3_i),
    .addr_lo (addr_lo_i),
    .mem_we  (mem_we_o),
    .rd_mask (rd_mask_o),
    .mem_rd  (mem_rd_o)
  );

  ctl_flow_dec u_flow (
    .cls          (cls),
    .funct3       (funct3_i),
    .alu_zero     (alu_zero_i),
    .pc_sel       (pc_sel_o),
    .tgt_base_sel (tgt_base_sel_o),
    .tgt_lsb_clr  (tgt_lsb_clr_o)
  );

  always_comb begin
    res_sel     = RES_ALU;
    imm_fmt     = IMM_I;
    alu_b_sel_o = 1'b0;
    reg_we_o    = 1'b0;
    unique case (cls)
      CLS_OP:     reg_we_o = 1'b1;
      CLS_OPIMM:  begin reg_we_o = 1'b1; alu_b_sel_o = 1'b1; end
      CLS_LOAD:   begin reg_we_o = 1'b1; alu_b_sel_o = 1'b1; res_sel = RES_MEM; end
      CLS_STORE:  begin alu_b_sel_o = 1'b1; imm_fmt = IMM_S; end
      CLS_BRANCH: imm_fmt = IMM_B;
      CLS_JAL:    begin reg_we_o = 1'b1; res_sel = RES_PC4; imm_fmt = IMM_J; end
      CLS_JALR:   begin reg_we_o = 1'b1; alu_b_sel_o = 1'b1; res_sel = RES_PC4; end
      CLS_LUI:    begin reg_we_o = 1'b1; res_sel = RES_IMM; imm_fmt = IMM_U; end
      CLS_AUIPC:  begin reg_we_o = 1'b1; res_sel = RES_TGT; imm_fmt = IMM_U; end
      default: ;
    endcase
  end

  assign res_sel_o = res_sel;
  assign imm_fmt_o = imm_fmt;
  assign alu_op_o  = alu_op;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk #(
  parameter int LANES = 4,
  localparam int LANE_IDX_W = $clog2(LANES)
) (
  input logic [6:0]            opcode_i,
  input logic [2:0]            funct3_i,
  input logic [6:0]            funct7_i,
  input logic                  alu_zero_i,
  input logic [LANE_IDX_W-1:0] addr_lo_i,
  input logic [2:0]            res_sel_o,
  input logic                  alu_b_sel_o,
  input logic                  pc_sel_o,
  input logic                  tgt_base_sel_o,
  input logic                  tgt_lsb_clr_o,
  input logic [2:0]            imm_fmt_o,
  input logic [2:0]            rd_mask_o,
  input logic                  mem_rd_o,
  input logic                  reg_we_o,
  input logic [LANES-1:0]      mem_we_o,
  input logic [3:0]            alu_op_o
);
  logic known_opc;
  int   lane_cnt;

  always_comb begin
    known_opc = (opcode_i == 7'b0000011) || (opcode_i == 7'b0100011) ||
                (opcode_i == 7'b0010011) || (opcode_i == 7'b0110011) ||
                (opcode_i == 7'b1100011) || (opcode_i == 7'b1101111) ||
                (opcode_i == 7'b1100111) || (opcode_i == 7'b0110111) ||
                (opcode_i == 7'b0010111);
    lane_cnt = $countones(mem_we_o);

    // R9: an unknown opcode leaves every write and redirect idle
    if (!known_opc)
      a_r9_unknown_quiet: assert (!reg_we_o && mem_we_o == '0 && !mem_rd_o && !pc_sel_o)
        else $error("unknown opcode produced activity");

    // R4: store lanes form a byte, a halfword or the full word
    a_r4_lane_shape: assert (lane_cnt == 0 || lane_cnt == 1 || lane_cnt == 2 || lane_cnt == LANES)
      else $error("store lane pattern malformed");

    // R4: a store never writes the register file or strobes a load
    if (mem_we_o != '0)
      a_r4_store_exclusive: assert (!reg_we_o && !mem_rd_o && opcode_i == 7'b0100011)
        else $error("store lanes with conflicting controls");

    // R3: a load strobe routes memory data and adds an immediate offset
    if (mem_rd_o)
      a_r3_load_path: assert (res_sel_o == 3'd1 && alu_b_sel_o && reg_we_o && alu_op_o == 4'd0)
        else $error("load strobe with wrong datapath steering");

    // R7: clearing the target lsb only happens on a register-based jump
    if (tgt_lsb_clr_o)
      a_r7_lsb_base: assert (tgt_base_sel_o && pc_sel_o && res_sel_o == 3'd2)
        else $error("lsb clear without register-based redirect");

    // R6: a direct jump always redirects and links
    if (opcode_i == 7'b1101111)
      a_r6_jal_redirect: assert (pc_sel_o && reg_we_o && !tgt_base_sel_o)
        else $error("jal did not redirect and link");

    // R5: a branch never writes state
    if (opcode_i == 7'b1100011)
      a_r5_branch_nowrite: assert (!reg_we_o && mem_we_o == '0 && !mem_rd_o)
        else $error("branch wrote state");
  end
endmodule

bind rv32_ctl_decoder ctl_decoder_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_rv32_ctl_decoder.sv
module sim_rv32_ctl_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [6:0] opc = '0;
  logic [2:0] f3 = '0;
  logic [6:0] f7 = '0;
  logic       zf = 1'b0;
  logic [1:0] alo = '0;

  logic [2:0] res_sel, imm_fmt, rd_mask;
  logic       b_sel, pc_sel, tgt_sel, lsb_clr, mem_rd, reg_we;
  logic [3:0] mem_we, alu_op;

  rv32_ctl_decoder u0 (
    .opcode_i(opc), .funct3_i(f3), .funct7_i(f7), .alu_zero_i(zf), .addr_lo_i(alo),
    .res_sel_o(res_sel), .alu_b_sel_o(b_sel), .pc_sel_o(pc_sel),
    .tgt_base_sel_o(tgt_sel), .tgt_lsb_clr_o(lsb_clr), .imm_fmt_o(imm_fmt),
    .rd_mask_o(rd_mask), .mem_rd_o(mem_rd), .reg_we_o(reg_we),
    .mem_we_o(mem_we), .alu_op_o(alu_op)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [22:0] exp_q[$];
  string       req_q[$];

  // Expected bundle from the requirements:
  // {res, b_sel, pc_sel, tgt_sel, lsb_clr, imm, mask, mem_rd, reg_we, mem_we, alu_op}
  function automatic logic [3:0] arith(input logic [2:0] f, input logic alt, input logic is_reg);
    case (f)
      3'd0: return (alt && is_reg) ? 4'd1 : 4'd0;
      3'd1: return 4'd7;
      3'd2: return 4'd5;
      3'd3: return 4'd6;
      3'd4: return 4'd4;
      3'd5: return alt ? 4'd9 : 4'd8;
      3'd6: return 4'd3;
      default: return 4'd2;
    endcase
  endfunction

  function automatic logic [22:0] model(input logic [6:0] o, input logic [2:0] f,
                                        input logic [6:0] s, input logic z, input logic [1:0] a);
    logic [2:0] res = 0, imm = 0, mask = 3'd2;
    logic bs = 0, pc = 0, ts = 0, lc = 0, mr = 0, rw = 0;
    logic [3:0] mw = 0, op = 0;
    case (o)
      7'b0110011: if (s == 7'h00 || (s == 7'h20 && (f == 3'd0 || f == 3'd5))) begin
        rw = 1; op = arith(f, s[5], 1'b1); end
      7'b0010011: if ((f == 3'd1) ? (s == 7'h00) : (f == 3'd5) ? (s == 7'h00 || s == 7'h20) : 1'b1) begin
        rw = 1; bs = 1; op = arith(f, s[5], 1'b0); end
      7'b0000011: if (f == 3'd0 || f == 3'd1 || f == 3'd2 || f == 3'd4 || f == 3'd5) begin
        rw = 1; bs = 1; res = 3'd1; mr = 1; mask = f; end
      7'b0100011: if (f <= 3'd2) begin
        bs = 1; imm = 3'd1;
        if (f == 3'd0) mw = 4'b0001 << a;
        else if (f == 3'd1) mw = (a == 2'd0) ? 4'b0011 : (a == 2'd2) ? 4'b1100 : 4'b0000;
        else mw = (a == 2'd0) ? 4'b1111 : 4'b0000;
      end
      7'b1100011: if (f != 3'd2 && f != 3'd3) begin
        imm = 3'd2;
        op = (f[2] == 1'b0) ? 4'd1 : (f[1] ? 4'd6 : 4'd5);
        case (f)
          3'd0, 3'd5, 3'd7: pc = z;
          default:          pc = !z;
        endcase
      end
      7'b1101111: begin rw = 1; pc = 1; res = 3'd2; imm = 3'd4; end
      7'b1100111: if (f == 3'd0) begin rw = 1; bs = 1; pc = 1; ts = 1; lc = 1; res = 3'd2; end
      7'b0110111: begin rw = 1; res = 3'd3; imm = 3'd3; end
      7'b0010111: begin rw = 1; res = 3'd4; imm = 3'd3; end
      default: ;
    endcase
    return {res, bs, pc, ts, lc, imm, mask, mr, rw, mw, op};
  endfunction

  task automatic drive(input logic [6:0] o, input logic [2:0] f, input logic [6:0] s,
                       input logic z, input logic [1:0] a, input string req);
    @(posedge clk);
    opc = o; f3 = f; f7 = s; zf = z; alo = a;
    exp_q.push_back(model(o, f, s, z, a));
    req_q.push_back(req);
  endtask

  // Monitor: compare one scoreboard item per cycle, away from the driving edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [22:0] e, act;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      act = {res_sel, b_sel, pc_sel, tgt_sel, lsb_clr, imm_fmt, rd_mask, mem_rd, reg_we, mem_we, alu_op};
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: opc=%b f3=%b f7=%b z=%b a=%0d actual=%h expected=%h",
                 r, opc, f3, f7, zf, alo, act, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(7'b0000000, 3'd0, 7'h00, 1'b0, 2'd0, "R9 reset-state idle word");
    for (int i = 0; i < 8; i++) drive(7'b0110011, 3'(i), 7'h00, 1'b0, 2'd0, "R1 reg-reg base");
    drive(7'b0110011, 3'd0, 7'h20, 1'b0, 2'd0, "R1 sub");
    drive(7'b0110011, 3'd5, 7'h20, 1'b0, 2'd0, "R1 sra");
    drive(7'b0110011, 3'd4, 7'h20, 1'b0, 2'd0, "R1 alt on xor rejected");
    drive(7'b0110011, 3'd0, 7'h01, 1'b0, 2'd0, "R1 reserved funct7 rejected");
    for (int i = 0; i < 8; i++) drive(7'b0010011, 3'(i), 7'h00, 1'b0, 2'd0, "R2 imm base");
    drive(7'b0010011, 3'd0, 7'h20, 1'b0, 2'd0, "R2 addi ignores bit30");
    drive(7'b0010011, 3'd5, 7'h20, 1'b0, 2'd0, "R2 srai");
    drive(7'b0010011, 3'd1, 7'h20, 1'b0, 2'd0, "R2 slli bad funct7");
    drive(7'b0010011, 3'd5, 7'h40, 1'b0, 2'd0, "R2 shift bad funct7");
    for (int i = 0; i < 8; i++) drive(7'b0000011, 3'(i), 7'h00, 1'b0, 2'd0, "R3 load widths");
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 4; a++) drive(7'b0100011, 3'(f), 7'h00, 1'b0, 2'(a), "R4 store lanes");
    drive(7'b0100011, 3'd4, 7'h00, 1'b0, 2'd0, "R4 store funct3 100 rejected");
    for (int f = 0; f < 8; f++)
      for (int z = 0; z < 2; z++) drive(7'b1100011, 3'(f), 7'h00, 1'(z), 2'd0, "R5 branch resolve");
    drive(7'b1101111, 3'd3, 7'h55, 1'b0, 2'd1, "R6 jal");
    drive(7'b1100111, 3'd0, 7'h00, 1'b1, 2'd0, "R7 jalr");
    drive(7'b1100111, 3'd1, 7'h00, 1'b0, 2'd0, "R7 jalr bad funct3");
    drive(7'b0110111, 3'd2, 7'h11, 1'b0, 2'd0, "R8 lui");
    drive(7'b0010111, 3'd6, 7'h22, 1'b0, 2'd0, "R8 auipc");
    drive(7'b0001111, 3'd0, 7'h00, 1'b0, 2'd0, "R9 fence quiet");
    drive(7'b1110011, 3'd0, 7'h00, 1'b0, 2'd0, "R9 system quiet");
    drive(7'b1111111, 3'd7, 7'h7f, 1'b1, 2'd3, "R9 all-ones quiet");
    drive(7'b0100011, 3'd1, 7'h00, 1'b0, 2'd2, "R10 history-free sh");
    drive(7'b1100011, 3'd1, 7'h00, 1'b0, 2'd0, "R10 history-free bne");
    drive(7'b0100011, 3'd1, 7'h00, 1'b0, 2'd2, "R10 history-free sh repeat");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule